// File: doc/BRIEF.md
# Global-History Direction Predictor with Late History Pick

This block predicts whether a conditional branch will be taken. It keeps a register of recent branch outcomes and a table of 2-bit saturating counters. Each lookup selects one counter through an index: the low bits of the branch PC XORed with the outcome history. A counter in its upper half predicts taken. When the branch resolves, the counter selected at prediction time moves toward the actual outcome.

Lookups are split over two cycles so that the table read can begin before the newest few outcomes are known. In the lookup cycle, the block takes the history bits that are already settled. It reads every counter that the unknown low history bits could select, which is 2^LATE_W candidates, and holds them. In the following fetch cycle, the caller supplies the newest outcomes on `lateHist`. A small mux picks the matching candidate, so only that narrow select remains on the late path. A restore input lets the pipeline replace the history with a corrected value after a misprediction.

Top module: `gshare_lookahead`

## Requirements
- R1: After reset, `histOut` is 0, `predValid` is 0, and every counter holds 01 (weakly not-taken), so any lookup predicts not-taken.
- R2: For a lookup presented in cycle t with PC bits `lookupPc` and history H (value of `histOut` in cycle t), `predIndex` in cycle t+1 equals `lookupPc ^ {H[HIST_W-LATE_W-1:0], lateHist}`, zero-extended to IDX_W bits, where `lateHist` is the value driven in cycle t+1.
- R3: `predTaken` equals bit 1 (the MSB) of the counter at `predIndex` as it stood when the lookup was presented.
- R4: `predValid` is 1 in exactly the cycle after a cycle with `lookupValid` high, and 0 otherwise.
- R5: The pick among candidates is combinational on `lateHist` during the pick cycle: changing `lateHist` within that cycle changes `predIndex` and `predTaken` without a new lookup.
- R6: An update with `updValid` increments the counter at `updIndex` when `updTaken` is 1 and decrements it when 0, saturating at 3 and at 0.
- R7: With `histShift` high and `histRestore` low, history becomes `{history[HIST_W-2:0], histTaken}` on the next edge (taken encoded as 1, not-taken as 0).
- R8: With `histRestore` high, history loads `histRestoreValue` on the next edge, overriding a simultaneous shift.
- R9: An update in the same cycle as a lookup does not affect that lookup's candidates: the prediction reflects the counter before the update.
- R10: With neither `histShift` nor `histRestore` high, history holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Starts a lookup this cycle |
| lookupPc | input | IDX_W | Low word-address bits of the branch PC |
| lateHist | input | LATE_W | Newest outcomes, driven in the pick cycle |
| predValid | output | 1 | Prediction outputs valid this cycle |
| predTaken | output | 1 | Predicted direction, 1 = taken |
| predIndex | output | IDX_W | Table index used, saved by the caller for update |
| updValid | input | 1 | Apply a resolved outcome to the table |
| updIndex | input | IDX_W | Index saved at prediction time |
| updTaken | input | 1 | Resolved outcome, 1 = taken |
| histShift | input | 1 | Shift one outcome into history |
| histTaken | input | 1 | Outcome shifted in, 1 = taken |
| histRestore | input | 1 | Load a corrected history |
| histRestoreValue | input | HIST_W | Corrected history value |
| histOut | output | HIST_W | Current history register |

## Verification
Two pairs of functions can share a cycle. The first is a history restore together with a history shift. The bench issues both in one cycle and expects the restore value alone on `histOut` after the edge. The second is a table update aimed at the exact entry that a lookup in the same cycle is capturing. In that case, the bench expects the pick cycle to report the counter's old direction, and a second lookup to report the updated one.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch candidate counters and base index
    logic ghrLoad;   // replace history
    logic ghrShift;  // shift one outcome into history
    logic cntWrite;  // write one counter
    logic cntInc;    // direction of the counter write
  } gsStrobe_t;

  function automatic logic [1:0] satStep(input logic [1:0] cur, input logic inc);
    logic [1:0] nxt;
    if (inc) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else     nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lookupValid,
  input  logic      updValid,
  input  logic      updTaken,
  input  logic      histShift,
  input  logic      histRestore,
  output gsStrobe_t strobe,
  output logic      predValid
);

  always_comb begin
    strobe.capture  = lookupValid;
    strobe.ghrLoad  = histRestore;
    strobe.ghrShift = histShift & ~histRestore;  // restore has priority
    strobe.cntWrite = updValid;
    strobe.cntInc   = updTaken;
  end

  always_ff @(posedge clk) begin
    if (!rstN) predValid <= 1'b0;
    else       predValid <= lookupValid;
  end

endmodule

// File: rtl/gshare_dp.sv
module gshare_dp
  import gshare_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  parameter int LATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  gsStrobe_t         strobe,
  input  logic [IDX_W-1:0]  lookupPc,
  input  logic [LATE_W-1:0] lateHist,
  input  logic [IDX_W-1:0]  updIndex,
  input  logic              histTaken,
  input  logic [HIST_W-1:0] histRestoreValue,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predIndex,
  output logic [HIST_W-1:0] histOut
);

  localparam int ENTRIES = 1 << IDX_W;
  localparam int CANDS   = 1 << LATE_W;
  localparam int UPPER_W = HIST_W - LATE_W;

  logic [HIST_W-1:0] ghr;
  logic [1:0]        pht [ENTRIES];
  logic [1:0]        candRead [CANDS];
  logic [1:0]        candQ [CANDS];
  logic [IDX_W-1:0]  baseQ;
  logic [HIST_W-1:0] earlyHist;
  logic [IDX_W-1:0]  earlyIdx;

  // History register
  always_ff @(posedge clk) begin
    if (!rstN)                ghr <= '0;
    else if (strobe.ghrLoad)  ghr <= histRestoreValue;
    else if (strobe.ghrShift) ghr <= {ghr[HIST_W-2:0], histTaken};
  end
  assign histOut = ghr;

  // Early index: settled history moved up, unknown low bits left zero
  assign earlyHist = {ghr[UPPER_W-1:0], {LATE_W{1'b0}}};
  assign earlyIdx  = lookupPc ^ IDX_W'(earlyHist);

  // One read per possible value of the missing history bits
  for (genvar g = 0; g < CANDS; g++) begin : g_cand
    assign candRead[g] = pht[earlyIdx ^ IDX_W'(g)];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      for (int i = 0; i < CANDS; i++) candQ[i] <= 2'b01;
    end else if (strobe.capture) begin
      baseQ <= earlyIdx;
      for (int i = 0; i < CANDS; i++) candQ[i] <= candRead[i];
    end
  end

  // Late pick
  assign predTaken = candQ[lateHist][1];
  assign predIndex = baseQ ^ IDX_W'(lateHist);

  // Counter table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) pht[i] <= 2'b01;
    end else if (strobe.cntWrite) begin
      pht[updIndex] <= satStep(pht[updIndex], strobe.cntInc);
    end
  end

endmodule

// File: rtl/gshare_lookahead.sv
module gshare_lookahead
  import gshare_pkg::*;
#(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  parameter int LATE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [IDX_W-1:0]  lookupPc,
  input  logic [LATE_W-1:0] lateHist,
  output logic              predValid,
  output logic              predTaken,
  output logic [IDX_W-1:0]  predIndex,
  input  logic              updValid,
  input  logic [IDX_W-1:0]  updIndex,
  input  logic              updTaken,
  input  logic              histShift,
  input  logic              histTaken,
  input  logic              histRestore,
  input  logic [HIST_W-1:0] histRestoreValue,
  output logic [HIST_W-1:0] histOut
);

  gsStrobe_t strobe;

  gshare_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .updValid    (updValid),
    .updTaken    (updTaken),
    .histShift   (histShift),
    .histRestore (histRestore),
    .strobe      (strobe),
    .predValid   (predValid)
  );

  gshare_dp #(
    .IDX_W  (IDX_W),
    .HIST_W (HIST_W),
    .LATE_W (LATE_W)
  ) u_dp (
    .clk              (clk),
    .rstN             (rstN),
    .strobe           (strobe),
    .lookupPc         (lookupPc),
    .lateHist         (lateHist),
    .updIndex         (updIndex),
    .histTaken        (histTaken),
    .histRestoreValue (histRestoreValue),
    .predTaken        (predTaken),
    .predIndex        (predIndex),
    .histOut          (histOut)
  );

endmodule

// File: rtl/gshare_lookahead_chk.sv
module gshare_lookahead_chk #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10,
  parameter int LATE_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              lookupValid,
  input logic [IDX_W-1:0]  lookupPc,
  input logic [LATE_W-1:0] lateHist,
  input logic              predValid,
  input logic [IDX_W-1:0]  predIndex,
  input logic              histShift,
  input logic              histTaken,
  input logic              histRestore,
  input logic [HIST_W-1:0] histRestoreValue,
  input logic [HIST_W-1:0] histOut
);

  localparam int UPPER_W = HIST_W - LATE_W;

  logic [IDX_W-1:0]   pcSeen;
  logic [UPPER_W-1:0] upSeen;
  logic [IDX_W-1:0]   idxModel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcSeen <= '0;
      upSeen <= '0;
    end else if (lookupValid) begin
      pcSeen <= lookupPc;
      upSeen <= histOut[UPPER_W-1:0];
    end
  end
  assign idxModel = pcSeen ^ IDX_W'({upSeen, lateHist});

  // R4
  pred_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> predValid);
  // R4
  pred_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !predValid);
  // R2
  index_form_chk: assert property (@(posedge clk) disable iff (!rstN)
    predValid |-> predIndex == idxModel);
  // R8
  restore_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    histRestore |=> histOut == $past(histRestoreValue));
  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    (histShift && !histRestore) |=> histOut == {$past(histOut[HIST_W-2:0]), $past(histTaken)});
  // R10
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!histShift && !histRestore) |=> $stable(histOut));

endmodule

bind gshare_lookahead gshare_lookahead_chk #(
  .IDX_W  (IDX_W),
  .HIST_W (HIST_W),
  .LATE_W (LATE_W)
) u_chk (
  .clk              (clk),
  .rstN             (rstN),
  .lookupValid      (lookupValid),
  .lookupPc         (lookupPc),
  .lateHist         (lateHist),
  .predValid        (predValid),
  .predIndex        (predIndex),
  .histShift        (histShift),
  .histTaken        (histTaken),
  .histRestore      (histRestore),
  .histRestoreValue (histRestoreValue),
  .histOut          (histOut)
);

// File: tb/gshare_lookahead_tb.sv
module gshare_lookahead_tb;

  localparam int IDX_W  = 10;
  localparam int HIST_W = 10;
  localparam int LATE_W = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lookupValid = 1'b0;
  logic [IDX_W-1:0]  lookupPc = '0;
  logic [LATE_W-1:0] lateHist = '0;
  logic              predValid, predTaken;
  logic [IDX_W-1:0]  predIndex;
  logic              updValid = 1'b0;
  logic [IDX_W-1:0]  updIndex = '0;
  logic              updTaken = 1'b0;
  logic              histShift = 1'b0;
  logic              histTaken = 1'b0;
  logic              histRestore = 1'b0;
  logic [HIST_W-1:0] histRestoreValue = '0;
  logic [HIST_W-1:0] histOut;

  int checks = 0;
  int fails = 0;
  int mdl [1 << IDX_W];
  logic [HIST_W-1:0] mdlGhr = '0;

  always #10 clk = ~clk;  // 50 MHz

  gshare_lookahead #(.IDX_W(IDX_W), .HIST_W(HIST_W), .LATE_W(LATE_W)) u_dut (
    .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupPc(lookupPc),
    .lateHist(lateHist), .predValid(predValid), .predTaken(predTaken),
    .predIndex(predIndex), .updValid(updValid), .updIndex(updIndex),
    .updTaken(updTaken), .histShift(histShift), .histTaken(histTaken),
    .histRestore(histRestore), .histRestoreValue(histRestoreValue),
    .histOut(histOut)
  );

  // {shift, taken, restore, value[9:0], expected[9:0]}
  localparam logic [22:0] HV [8] = '{
    {3'b110, 10'h000, 10'h001},   // R7
    {3'b110, 10'h000, 10'h003},   // R7
    {3'b100, 10'h000, 10'h006},   // R7
    {3'b001, 10'h2A5, 10'h2A5},   // R8
    {3'b111, 10'h155, 10'h155},   // R8 restore beats shift
    {3'b000, 10'h3FF, 10'h155},   // R10
    {3'b110, 10'h000, 10'h2AB},   // R7
    {3'b100, 10'h000, 10'h156}    // R7
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] expIdx(input logic [IDX_W-1:0] pc,
                                              input logic [LATE_W-1:0] late);
    return pc ^ IDX_W'({mdlGhr[HIST_W-LATE_W-1:0], late});
  endfunction

  task automatic doUpdate(input logic [IDX_W-1:0] idx, input logic t);
    @(negedge clk);
    updValid = 1'b1; updIndex = idx; updTaken = t;
    @(negedge clk);
    updValid = 1'b0;
    if (t) mdl[idx] = (mdl[idx] == 3) ? 3 : mdl[idx] + 1;
    else   mdl[idx] = (mdl[idx] == 0) ? 0 : mdl[idx] - 1;
  endtask

  task automatic setHist(input logic [HIST_W-1:0] v);
    @(negedge clk);
    histRestore = 1'b1; histRestoreValue = v;
    @(negedge clk);
    histRestore = 1'b0;
    mdlGhr = v;
  endtask

  // Presents a lookup; returns at the start of the pick cycle.
  task automatic doLookup(input logic [IDX_W-1:0] pc, input logic withUpd,
                          input logic [IDX_W-1:0] uIdx);
    @(negedge clk);
    lookupValid = 1'b1; lookupPc = pc;
    updValid = withUpd; updIndex = uIdx; updTaken = 1'b1;
    @(negedge clk);
    lookupValid = 1'b0; updValid = 1'b0;
    if (withUpd) mdl[uIdx] = (mdl[uIdx] == 3) ? 3 : mdl[uIdx] + 1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [IDX_W-1:0] ei;
    int et;
    for (int i = 0; i < (1 << IDX_W); i++) mdl[i] = 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(predValid == 1'b0, "R1 predValid", predValid, 0);
    check(histOut == '0, "R1 histOut", histOut, 0);

    // History vectors: R7 R8 R10
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      histShift = HV[v][22]; histTaken = HV[v][21]; histRestore = HV[v][20];
      histRestoreValue = HV[v][19:10];
      @(negedge clk);
      histShift = 1'b0; histRestore = 1'b0;
      #1;
      check(histOut == HV[v][9:0], "R7/R8/R10 history vector", histOut, HV[v][9:0]);
    end
    mdlGhr = 10'h156;

    // R1 R2 R4: fresh table, zero history
    setHist('0);
    doLookup(10'h123, 1'b0, '0);
    lateHist = 3'd0; #1;
    check(predValid == 1'b1, "R4 valid in pick cycle", predValid, 1);
    check(predIndex == 10'h123, "R2 index zero history", predIndex, 10'h123);
    check(predTaken == 1'b0, "R1 counters reset to 01", predTaken, 0);
    @(negedge clk); #1;
    check(predValid == 1'b0, "R4 valid drops", predValid, 0);

    // R3 R5: train 0x045, pick among candidates of pc 0x040
    doUpdate(10'h045, 1'b1);
    doUpdate(10'h045, 1'b1);
    doLookup(10'h040, 1'b0, '0);
    lateHist = 3'd5; #1;
    check(predIndex == 10'h045, "R5 late pick index 5", predIndex, 10'h045);
    check(predTaken == 1'b1, "R3 trained counter taken", predTaken, 1);
    lateHist = 3'd4; #1;
    check(predIndex == 10'h044, "R5 late pick index 4", predIndex, 10'h044);
    check(predTaken == 1'b0, "R5 other candidate not taken", predTaken, 0);

    // R6 upper saturation: 3 +1 -> 3, -1 -> 2 (taken)
    doUpdate(10'h045, 1'b1);
    doUpdate(10'h045, 1'b0);
    doLookup(10'h040, 1'b0, '0);
    lateHist = 3'd5; #1;
    check(predTaken == 1'b1, "R6 saturate at 3", predTaken, 1);

    // R6 lower saturation: down to 0 and beyond, then +2 -> 2 (taken)
    for (int k = 0; k < 4; k++) doUpdate(10'h045, 1'b0);
    doUpdate(10'h045, 1'b1);
    doUpdate(10'h045, 1'b1);
    doLookup(10'h040, 1'b0, '0);
    lateHist = 3'd5; #1;
    check(predTaken == (mdl[10'h045] >= 2), "R6 saturate at 0", predTaken, 1);

    // R2 with non-zero history
    setHist(10'h2A5);
    ei = expIdx(10'h3C7, 3'd6);
    et = mdl[ei];
    doLookup(10'h3C7, 1'b0, '0);
    lateHist = 3'd6; #1;
    check(predIndex == ei, "R2 index with history", predIndex, ei);
    check(predTaken == (et >= 2), "R3 history-indexed counter", predTaken, int'(et >= 2));

    // R9: update same cycle as lookup to the captured entry
    setHist('0);
    et = mdl[10'h100];
    doLookup(10'h100, 1'b1, 10'h100);
    lateHist = 3'd0; #1;
    check(predTaken == (et >= 2), "R9 lookup sees old counter", predTaken, int'(et >= 2));
    doLookup(10'h100, 1'b0, '0);
    lateHist = 3'd0; #1;
    check(predTaken == (mdl[10'h100] >= 2), "R9 later lookup sees update", predTaken, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule